// File: doc/BRIEF.md
# Millisecond Delay Unit with Call Handshake

This block is a hardware delay routine that a controller calls the way software calls a function that returns nothing. The caller waits until `idle` is high, puts a millisecond count on `ms_arg` and raises `start` for one cycle. The unit then counts clock cycles and reports the end of the interval with a single `valid` pulse. There is no result port, because the call returns no value.

A prescaler turns the clock into one-millisecond ticks. It runs for `CLK_HZ / 1000` cycles per tick. A down-counter holds the number of milliseconds still to wait, and a small state machine runs the handshake. The unit handles one call at a time. A `start` that arrives while a call is running has no effect, and a running call cannot be paused or cancelled except by reset.

Top module: `ms_delay_call`

## Requirements
- R1: While `rst_n` is low, `idle` is 1 and `valid` is 0. After reset, no `valid` pulse comes from a call that was interrupted by the reset. The next call then takes its full length, because the prescaler and the counter start again from zero.
- R2: A call is accepted only at a rising edge where both `idle` and `start` are 1. A `start` while `idle` is 0 is ignored: it produces no extra `valid` and leaves the running call's completion time unchanged.
- R3: `ms_arg` is captured at the accepting edge. Changes to `ms_arg` after that edge do not change the delay.
- R4: For a nonzero count, `idle` is 0 from the cycle after the accepting edge until the completion cycle.
- R5: For a count N ≥ 1, `valid` goes high at the rising edge N × (`CLK_HZ` / 1000) clock edges after the accepting edge.
- R6: A count of 0 raises `valid` in the cycle right after the accepting edge, and `idle` stays high throughout.
- R7: `valid` lasts one cycle unless a new zero-length call is accepted in that same cycle. `idle` is 1 whenever `valid` is 1.
- R8: A new call can be accepted in the same cycle as the previous call's `valid`, so calls can run back to back with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, at frequency `CLK_HZ` |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_arg | input | ARG_W (32) | Delay length in milliseconds, sampled when a call is accepted |
| start | input | 1 | Call request, taken only while `idle` is high |
| idle | output | 1 | High when the unit can accept a call |
| valid | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check on every cycle the properties that involve only adjacent cycles:
- the prescaler count stays inside its bound;
- the millisecond counter never ticks at zero and holds its value between ticks;
- an accepted call drops `idle`, or raises `valid` at once for a zero count;
- a `start` is ignored while the unit is busy;
- `valid` falls back after one cycle.

Only the bench scenarios can show the end-to-end timing. These are:
- the exact N × cycles-per-millisecond latency for several counts;
- that a changed argument after acceptance has no effect;
- back-to-back calls issued in the completion cycle;
- that a reset in the middle of a call cancels it without a stray pulse.

The bench checks these timings against a scoreboard of expected completion cycles.

// File: rtl/ms_delay_pkg.sv
package ms_delay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } call_state_e;

    typedef struct packed {
        call_state_e state;
    } fsm_regs_t;

endpackage

// File: rtl/ms_tick_prescaler.sv
module ms_tick_prescaler #(
    parameter int CYC_PER_MS = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_regs_t;

    pre_regs_t r_d, r_q;

    assign tick = en && (r_q.cnt == PRE_LAST);

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (en) begin
            r_d.cnt = tick ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Count never passes the last cycle of a millisecond (R5)
    assert_prescale_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= PRE_LAST);

endmodule

// File: rtl/ms_count_down.sv
module ms_count_down #(
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ARG_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    typedef struct packed {
        logic [ARG_W-1:0] remaining;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    assign last = (r_q.remaining == ARG_W'(1));

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.remaining = load_val;
        end else if (tick) begin
            r_d.remaining = r_q.remaining - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // A tick never arrives with nothing left to count (R5)
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (r_q.remaining != '0));

    // The captured count only moves on ticks (R3)
    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(r_q.remaining));

endmodule

// File: rtl/ms_call_fsm.sv
module ms_call_fsm
    import ms_delay_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic arg_zero,
    input  logic last_tick,
    output logic load,
    output logic run,
    output logic idle,
    output logic valid
);
    fsm_regs_t r_d, r_q;

    assign run   = (r_q.state == ST_RUN);
    assign idle  = (r_q.state != ST_RUN);
    assign valid = (r_q.state == ST_FIN);
    assign load  = idle && start;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_FIN: begin
                if (start) begin
                    r_d.state = arg_zero ? ST_FIN : ST_RUN;
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (last_tick) begin
                    r_d.state = ST_FIN;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assert_accept_drops_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !arg_zero) |=> !idle);

    assert_zero_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && arg_zero) |=> (valid && idle));

    assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && start && !last_tick) |=> !idle);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> (!valid && idle));

endmodule

// File: rtl/ms_delay_call.sv
module ms_delay_call #(
    parameter int CLK_HZ = 100_000_000,
    parameter int ARG_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ARG_W-1:0] ms_arg,
    input  logic             start,
    output logic             idle,
    output logic             valid
);
    localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

    logic load, run, tick, last, last_tick, arg_zero;

    assign arg_zero  = (ms_arg == '0);
    assign last_tick = tick && last;

    ms_tick_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (run),
        .tick  (tick)
    );

    ms_count_down #(.ARG_W(ARG_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (ms_arg),
        .tick     (tick),
        .last     (last)
    );

    ms_call_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .arg_zero  (arg_zero),
        .last_tick (last_tick),
        .load      (load),
        .run       (run),
        .idle      (idle),
        .valid     (valid)
    );

endmodule

// File: tb/tb_ms_delay_call.sv
module tb_ms_delay_call;
    localparam int HZ  = 8000;
    localparam int CYC = HZ / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ms_arg = '0;
    logic        idle, valid;

    int cyc = 0;
    int pass_n = 0;
    int total_n = 0;
    bit reported = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ms_delay_call #(.CLK_HZ(HZ), .ARG_W(32)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_arg (ms_arg),
        .start  (start),
        .idle   (idle),
        .valid  (valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total_n++;
        if (ok) pass_n++;
        else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", pass_n, total_n);
        end
        $finish;
    endtask

    // Monitor: each valid pulse pops one expected completion cycle
    always @(negedge clk) begin
        if (rst_n && valid) begin
            check(idle, "R7 idle high with valid", int'(idle), 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected valid", cyc, -1);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cyc == e, t, cyc, e);
            end
        end
    end

    // Driver: wait for idle, issue call, push expected completion cycle
    task automatic call(input int n, input string tag);
        @(negedge clk);
        while (!idle) @(negedge clk);
        ms_arg = n;
        start = 1'b1;
        exp_q.push_back(cyc + 1 + n * CYC);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        ms_arg = 32'hFFFF_FFFF; // R3: later argument changes must not matter
        if (n != 0) check(!idle, "R4 idle low after accept", int'(idle), 0);
        else check(valid && idle, "R6 zero call valid next cycle", int'(valid), 1);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        check(1'b0, "watchdog expired", cyc, -1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R1 idle in reset", int'(idle), 1);
        check(valid == 1'b0, "R1 valid low in reset", int'(valid), 0);
        rst_n = 1'b1;

        call(1, "R5 one ms latency");
        drain();
        call(3, "R5 three ms latency and R3 arg latched");
        drain();
        call(0, "R6 zero ms completion");
        drain();

        // R2: start while busy is ignored
        call(2, "R2 busy start ignored, R5 two ms");
        repeat (3) @(negedge clk);
        ms_arg = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!idle, "R2 still busy after ignored start", int'(idle), 0);
        drain();

        // R8: back-to-back calls issued in the completion cycle
        call(1, "R8 first call");
        call(2, "R8 back-to-back second call");
        call(0, "R8 zero call after valid");
        call(0, "R8 consecutive zero call");
        drain();

        // R1: reset mid-call cancels it
        call(5, "R1 cancelled call");
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        tag_q.delete();
        @(negedge clk);
        check(idle && !valid, "R1 reset clears busy call", int'(idle), 1);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        check(idle, "R1 idle after cancelled call", int'(idle), 1);
        call(1, "R1 full length after reset");
        drain();

        check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
        report();
    end
endmodule